// File: doc/BRIEF.md
# Flash Lock-Region Command Controller

This block keeps the write and erase protection bits of an embedded flash array. Each protection bit guards one lock region, which is a run of consecutive pages. Software drives the block through four word-wide registers. A control register holds the interrupt enable. A command register takes a key byte, a page argument and an operation code. A status register shows the ready and error flags. A result register returns the protection bits as a stream of 32-bit words.

Three operations are accepted: lock the region that holds a page, unlock the region that holds a page, and snapshot the protection bits for read-back. Once a command is accepted, the block spends a fixed number of cycles executing it and then raises its ready flag. The interrupt line is active while the block is ready and the interrupt enable is set. The flash program and erase path asks through a separate port whether a page may be changed, and the block refuses pages in locked regions.

Top module: `flash_lock_ctrl`

## Requirements
- R1: After reset the status register reads 1 (bit 0 ready = 1, bit 1 command error = 0), all regions are unlocked, the interrupt line is low, and result reads return 0.
- R2: Command word layout: bits [31:24] key (0xC5), bits [23:8] page, bits [7:0] operation (0x21 lock, 0x22 unlock, 0x23 snapshot). A lock command sets the bit of region page / PAGES_PER_REGION, and `pe_deny` then reads 1 for every page of that region while `pe_req` is high. It reads 0 for pages outside locked regions and whenever `pe_req` is low.
- R3: An unlock command clears the bit of the region holding its page, after which program and erase of that region is no longer denied.
- R4: An accepted command drops the ready flag in the cycle after the write. The ready flag and the command's effect appear EXEC_CYCLES clock edges after the accepting edge.
- R5: Control register bit 0 enables the interrupt. With it set, `irq` is high exactly while the block is ready. With it clear, `irq` stays low even when a command completes.
- R6: A command write whose key is not 0xC5 sets the command error flag (status bit 1), leaves ready high, and changes no lock bit.
- R7: Command writes made while ready is low are ignored. They change no lock bit and raise no error.
- R8: A lock or unlock whose page maps beyond region NUM_REGIONS-1 sets the command error flag and changes no lock bit.
- R9: After a snapshot completes, successive result reads return lock bits 32k..32k+31 for k = 0, 1, ..., with bit n of word 0 being region n. Unimplemented bits and reads past the last word return 0.
- R10: A read of the status register clears the command error flag after returning it.
- R11: A command write with a correct key but an operation code outside the three defined codes sets the command error flag and is not executed.
- R12: The snapshot command ignores its page argument, and an out-of-range page does not make it fail.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | 2 | Register select: 0 control, 1 command, 2 status, 3 result |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the selected register (combinational) |
| pe_req | input | 1 | Program/erase request from the flash path |
| pe_page | input | 16 | Page targeted by the program/erase request |
| pe_deny | output | 1 | Request refused because the page's region is locked |
| irq | output | 1 | Interrupt: ready while the enable is set |

## Verification
A corrupted protection bit shows up on `pe_deny` in the same cycle a request reaches that region, and on the result stream at the next snapshot. A wrong page-to-region mapping shows up when the bench probes the pages on each side of a region boundary. A stuck execution counter or a wrong ready flag shows up as an `irq` edge on the wrong cycle. The bench checks that edge at exactly EXEC_CYCLES edges after acceptance. An error flag that is not set or not cleared shows up on the very next status read.

// File: rtl/flk_pkg.sv
package flk_pkg;

    localparam int          PAGE_W    = 16;
    localparam logic [7:0]  KEY_VALUE = 8'hC5;
    localparam logic [7:0]  OPC_LOCK  = 8'h21;
    localparam logic [7:0]  OPC_UNLK  = 8'h22;
    localparam logic [7:0]  OPC_SNAP  = 8'h23;

    typedef enum logic [1:0] {
        REG_CTRL   = 2'd0,
        REG_CMD    = 2'd1,
        REG_STATUS = 2'd2,
        REG_RESULT = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_LOCK = 2'd1,
        ACT_UNLK = 2'd2,
        ACT_SNAP = 2'd3
    } lk_act_e;

    typedef struct packed {
        logic              key_ok;
        lk_act_e           act;
        logic [PAGE_W-1:0] page;
    } lk_cmd_t;

    function automatic lk_act_e opc_to_act(input logic [7:0] opc);
        case (opc)
            OPC_LOCK: return ACT_LOCK;
            OPC_UNLK: return ACT_UNLK;
            OPC_SNAP: return ACT_SNAP;
            default:  return ACT_NONE;
        endcase
    endfunction

endpackage

// File: rtl/flk_decode.sv
module flk_decode
    import flk_pkg::*;
(
    input  logic [31:0] word,
    output lk_cmd_t     cmd
);
    always_comb begin
        cmd.key_ok = (word[31:24] == KEY_VALUE);
        cmd.page   = word[8 +: PAGE_W];
        cmd.act    = opc_to_act(word[7:0]);
    end
endmodule

// File: rtl/flk_lock_bits.sv
module flk_lock_bits
    import flk_pkg::*;
#(
    parameter int NUM_REGIONS = 40
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   upd,
    input  logic                   set_val,
    input  logic [PAGE_W-1:0]      region,
    output logic [NUM_REGIONS-1:0] locks
);
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst)
                locks[g] <= 1'b0;
            else if (upd && region == PAGE_W'(g))
                locks[g] <= set_val;
        end
    end
endmodule

// File: rtl/flk_result_stream.sv
module flk_result_stream #(
    parameter int NUM_REGIONS = 40,
    localparam int WORDS = (NUM_REGIONS + 31) / 32,
    localparam int PTR_W = $clog2(WORDS + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   restart,
    input  logic                   advance,
    input  logic [NUM_REGIONS-1:0] locks,
    output logic [31:0]            word,
    output logic [PTR_W-1:0]       ptr
);
    logic [WORDS*32-1:0] padded;
    logic [31:0]         words [WORDS+1];

    assign padded = {{(WORDS*32-NUM_REGIONS){1'b0}}, locks};

    for (genvar w = 0; w < WORDS; w++) begin : g_word
        assign words[w] = padded[w*32 +: 32];
    end
    assign words[WORDS] = 32'd0;

    always_ff @(posedge clk) begin
        if (rst)
            ptr <= PTR_W'(WORDS);
        else if (restart)
            ptr <= '0;
        else if (advance && ptr < PTR_W'(WORDS))
            ptr <= ptr + 1'b1;
    end

    assign word = words[ptr];
endmodule

// File: rtl/flash_lock_ctrl.sv
module flash_lock_ctrl
    import flk_pkg::*;
#(
    parameter int NUM_REGIONS      = 40,
    parameter int PAGES_PER_REGION = 16,
    parameter int EXEC_CYCLES      = 4,
    localparam int WORDS = (NUM_REGIONS + 31) / 32,
    localparam int PTR_W = $clog2(WORDS + 1),
    localparam int CNT_W = $clog2(EXEC_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              pe_req,
    input  logic [PAGE_W-1:0] pe_page,
    output logic              pe_deny,
    output logic              irq
);
    lk_cmd_t                dec;
    logic [PAGE_W-1:0]      cmd_region, pe_region, pend_region;
    lk_act_e                pend_act;
    logic                   ready, cmd_err, irq_en;
    logic [CNT_W-1:0]       cnt;
    logic                   cmd_wr, bad, accept, reject, done, status_rd;
    logic [NUM_REGIONS-1:0] locks;
    logic [31:0]            res_word;
    logic [PTR_W-1:0]       res_ptr;

    flk_decode u_dec (.word(bus_wdata), .cmd(dec));

    assign cmd_wr     = bus_wr && bus_addr == REG_CMD;
    assign status_rd  = bus_rd && bus_addr == REG_STATUS;
    assign cmd_region = dec.page / PAGE_W'(PAGES_PER_REGION);
    assign pe_region  = pe_page / PAGE_W'(PAGES_PER_REGION);

    always_comb begin
        bad = !dec.key_ok || dec.act == ACT_NONE;
        if ((dec.act == ACT_LOCK || dec.act == ACT_UNLK) &&
            cmd_region >= PAGE_W'(NUM_REGIONS))
            bad = 1'b1;
    end

    assign accept = cmd_wr && ready && !bad;
    assign reject = cmd_wr && ready && bad;
    assign done   = !ready && cnt == CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ready       <= 1'b1;
            cnt         <= '0;
            pend_act    <= ACT_NONE;
            pend_region <= '0;
        end else if (accept) begin
            ready       <= 1'b0;
            cnt         <= CNT_W'(EXEC_CYCLES);
            pend_act    <= dec.act;
            pend_region <= cmd_region;
        end else if (!ready) begin
            cnt <= cnt - 1'b1;
            if (done)
                ready <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_err <= 1'b0;
            irq_en  <= 1'b0;
        end else begin
            if (reject)
                cmd_err <= 1'b1;
            else if (status_rd)
                cmd_err <= 1'b0;
            if (bus_wr && bus_addr == REG_CTRL)
                irq_en <= bus_wdata[0];
        end
    end

    flk_lock_bits #(.NUM_REGIONS(NUM_REGIONS)) u_bits (
        .clk     (clk),
        .rst     (rst),
        .upd     (done && (pend_act == ACT_LOCK || pend_act == ACT_UNLK)),
        .set_val (pend_act == ACT_LOCK),
        .region  (pend_region),
        .locks   (locks)
    );

    flk_result_stream #(.NUM_REGIONS(NUM_REGIONS)) u_res (
        .clk     (clk),
        .rst     (rst),
        .restart (done && pend_act == ACT_SNAP),
        .advance (bus_rd && bus_addr == REG_RESULT),
        .locks   (locks),
        .word    (res_word),
        .ptr     (res_ptr)
    );

    always_comb begin
        pe_deny = 1'b0;
        for (int i = 0; i < NUM_REGIONS; i++)
            if (pe_region == PAGE_W'(i) && locks[i])
                pe_deny = pe_req;
    end

    always_comb begin
        case (bus_addr)
            REG_CTRL:   bus_rdata = {31'd0, irq_en};
            REG_STATUS: bus_rdata = {30'd0, cmd_err, ready};
            REG_RESULT: bus_rdata = res_word;
            default:    bus_rdata = 32'd0;
        endcase
    end

    assign irq = ready && irq_en;
endmodule

// File: rtl/flash_lock_ctrl_chk.sv
module flash_lock_ctrl_chk #(
    parameter int NUM_REGIONS = 40,
    parameter int PTR_W       = 2,
    parameter int WORDS       = 2
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   ready,
    input logic                   cmd_err,
    input logic                   irq_en,
    input logic                   irq,
    input logic                   accept,
    input logic                   reject,
    input logic                   done,
    input logic                   bus_wr,
    input logic                   bus_rd,
    input logic [1:0]             bus_addr,
    input logic [31:0]            bus_rdata,
    input logic [NUM_REGIONS-1:0] locks,
    input logic [PTR_W-1:0]       res_ptr
);
    a_r4_ready_drop: assert property (@(posedge clk) disable iff (rst)
        accept |=> !ready);

    a_r7_busy_stable: assert property (@(posedge clk) disable iff (rst)
        (!ready && !done) |=> $stable(locks));

    a_r6_reject_keeps: assert property (@(posedge clk) disable iff (rst)
        reject |=> (cmd_err && ready && $stable(locks)));

    a_r10_err_clear: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd2 && !bus_wr) |=> !cmd_err);

    a_r5_irq_on_done: assert property (@(posedge clk) disable iff (rst)
        (done && irq_en && !bus_wr) |=> irq);

    a_r9_pad_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == 2'd3 && res_ptr >= PTR_W'(WORDS)) |-> bus_rdata == 32'd0);
endmodule

bind flash_lock_ctrl flash_lock_ctrl_chk #(
    .NUM_REGIONS (NUM_REGIONS),
    .PTR_W       (PTR_W),
    .WORDS       (WORDS)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ready     (ready),
    .cmd_err   (cmd_err),
    .irq_en    (irq_en),
    .irq       (irq),
    .accept    (accept),
    .reject    (reject),
    .done      (done),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .locks     (locks),
    .res_ptr   (res_ptr)
);

// File: tb/flash_lock_ctrl_bench.sv
module flash_lock_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NREG = 40;
    localparam int PPR  = 16;
    localparam int EXEC = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic        pe_req = 1'b0;
    logic [15:0] pe_page = 16'd0;
    logic        pe_deny, irq;

    int errors = 0;
    int checks = 0;
    logic [63:0] model = 64'd0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic [31:0] rd_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_lock_ctrl #(.NUM_REGIONS(NREG), .PAGES_PER_REGION(PPR),
                      .EXEC_CYCLES(EXEC)) u_flash_lock_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pe_req(pe_req), .pe_page(pe_page), .pe_deny(pe_deny), .irq(irq));

    task automatic check(input logic [31:0] act, input logic [31:0] exp,
                         input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pops expected result words as the design streams them
    always @(negedge clk) begin
        if (bus_rd && bus_addr == 2'd3) begin
            if (exp_q.size() == 0) begin
                checks++; errors++;
                $display("FAIL R9: actual=%h expected=<none queued>", bus_rdata);
            end else
                check(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic expect_result(input logic [31:0] exp, input string tag);
        logic [31:0] dummy;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_read(2'd3, dummy);
    endtask

    task automatic issue(input logic [7:0] key, input logic [15:0] page,
                         input logic [7:0] opc);
        bus_write(2'd1, {key, page, opc});
    endtask

    task automatic settle();
        repeat (EXEC + 2) @(posedge clk);
        #1;
    endtask

    task automatic probe(input logic [15:0] page, input logic exp,
                         input string tag);
        pe_req = 1'b1; pe_page = page; #1;
        check({31'd0, pe_deny}, {31'd0, exp}, tag);
        pe_req = 1'b0; #1;
    endtask

    task automatic status_is(input logic [31:0] exp, input string tag);
        bus_read(2'd2, rd_val);
        check(rd_val, exp, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk); #1;
        rst = 1'b0;
        // R1 reset state
        check({31'd0, irq}, 32'd0, "R1 irq after reset");
        status_is(32'd1, "R1 status after reset");
        expect_result(32'd0, "R1 result after reset");
        probe(16'd0, 1'b0, "R1 no lock after reset");

        // R5 enable interrupt: idle and ready -> irq high
        bus_write(2'd0, 32'd1);
        check({31'd0, irq}, 32'd1, "R5 irq while ready and enabled");

        // R2 + R4: lock page 37 (region 2), exact timing via irq
        issue(8'hC5, 16'd37, 8'h21);
        check({31'd0, irq}, 32'd0, "R4 ready low after accept");
        repeat (EXEC - 1) @(posedge clk); #1;
        check({31'd0, irq}, 32'd0, "R4 still busy one edge early");
        @(posedge clk); #1;
        check({31'd0, irq}, 32'd1, "R4 ready at EXEC edges");
        model[2] = 1'b1;
        status_is(32'd1, "R4 status ready no error");
        probe(16'd32, 1'b1, "R2 first page of region 2 denied");
        probe(16'd47, 1'b1, "R2 last page of region 2 denied");
        probe(16'd48, 1'b0, "R2 next region free");
        probe(16'd31, 1'b0, "R2 previous region free");
        pe_page = 16'd40; #1;
        check({31'd0, pe_deny}, 32'd0, "R2 no deny without request");

        // last region, then out of range
        issue(8'hC5, 16'd639, 8'h21); settle(); model[39] = 1'b1;
        probe(16'd639, 1'b1, "R2 last region locked");
        issue(8'hC5, 16'd640, 8'h21);
        status_is(32'd3, "R8 out-of-range error, ready stays");
        status_is(32'd1, "R10 error cleared by status read");
        probe(16'd640, 1'b0, "R8 beyond range not denied");

        // R6 bad key
        issue(8'h00, 16'd100, 8'h21); settle();
        status_is(32'd3, "R6 bad key error");
        probe(16'd100, 1'b0, "R6 bad key not executed");

        // R11 unknown opcode
        issue(8'hC5, 16'd100, 8'h7F); settle();
        status_is(32'd3, "R11 unknown opcode error");
        probe(16'd100, 1'b0, "R11 unknown opcode not executed");

        // R7 command while busy ignored
        issue(8'hC5, 16'd160, 8'h21);
        issue(8'hC5, 16'd176, 8'h21);
        settle(); model[10] = 1'b1;
        probe(16'd160, 1'b1, "R7 first command done");
        probe(16'd176, 1'b0, "R7 busy write ignored");
        status_is(32'd1, "R7 no error from busy write");

        // R3 unlock region 2
        issue(8'hC5, 16'd40, 8'h22); settle(); model[2] = 1'b0;
        probe(16'd32, 1'b0, "R3 region 2 unlocked");
        probe(16'd160, 1'b1, "R3 other region untouched");

        // R12 + R9 snapshot with out-of-range argument
        issue(8'hC5, 16'hFFFF, 8'h23); settle();
        status_is(32'd1, "R12 snapshot ignores argument");
        expect_result(model[31:0], "R9 word 0");
        expect_result(model[63:32], "R9 word 1 padded");
        expect_result(32'd0, "R9 past last word");
        expect_result(32'd0, "R9 past last word again");

        // R5 disabled interrupt stays low across completion
        bus_write(2'd0, 32'd0);
        issue(8'hC5, 16'd639, 8'h22);
        settle(); model[39] = 1'b0;
        check({31'd0, irq}, 32'd0, "R5 irq low when disabled");

        // R9 bit n is region n: lock region 0
        issue(8'hC5, 16'd15, 8'h21); settle(); model[0] = 1'b1;
        issue(8'hC5, 16'd0, 8'h23); settle();
        expect_result(model[31:0], "R9 region 0 is bit 0");
        expect_result(model[63:32], "R9 region 39 cleared");
        expect_result(32'd0, "R9 zero padding");

        @(posedge clk); #1;
        check(exp_q.size(), 32'd0, "R9 all results consumed");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule